// File: doc/BRIEF.md
# One-Position Right Shifter with Carry

This block shifts a data word right by exactly one position, toward its least significant bit, and selects what enters the vacated most significant bit from a 16-bit function field. Three variants are recognised: an arithmetic form that repeats the operand's sign bit, a rotate-through-carry form that inserts the incoming carry flag, and a logical form that inserts zero. In every variant the bit that falls off the least significant end becomes the new carry.

An execution stage presents one operation per cycle with `in_valid`. The result, the new carry, a carry write-enable and an illegal-code flag all appear together one clock later, qualified by `out_valid`. A function code that matches none of the three variants is flagged as illegal. It passes the operand through unchanged and hands back the incoming carry without asking for a write. Throughout this brief the vector is written `[W-1:0]`: index `W-1` is the most significant bit and index 0 is the least significant.

Top module: `shr1_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid`, `out_carry_we` and `out_illegal` are low, and `out_result` and `out_carry` are zero.
- R2: `out_valid` is high exactly on the cycle that follows a cycle with `in_valid` high, and is low otherwise.
- R3: For a legal function code, `out_result[W-2:0]` equals `in_opnd[W-1:1]` as presented one cycle earlier.
- R4: Function code 0x0001 (arithmetic) puts the operand's most significant bit into `out_result[W-1]`.
- R5: Function code 0x0021 (through carry) puts `in_carry` into `out_result[W-1]`.
- R6: Function code 0x0041 (logical) puts 0 into `out_result[W-1]`.
- R7: For a legal function code, `out_carry` equals the operand's least significant bit, `in_opnd[0]`.
- R8: `out_carry_we` is high only together with `out_valid` for a legal function code, and `out_illegal` is then low.
- R9: Any other function code raises `out_illegal` with `out_valid` and holds `out_carry_we` low. `out_carry` then equals the presented `in_carry` and `out_result` equals the operand unchanged.
- R10: On cycles without a valid input, `out_result` and `out_carry` keep the values of the last accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle |
| in_func | input | 16 | Function field selecting the shift variant |
| in_opnd | input | 32 | Operand to shift |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 32 | Shifted word |
| out_carry | output | 1 | New carry value |
| out_carry_we | output | 1 | Write strobe for the carry flag |
| out_illegal | output | 1 | Function code not recognised |

## Verification
On every cycle the assertions check the one-cycle valid timing, the shift of the lower bits, the fill bit each variant chooses, the carry taken from the least significant bit, and the exclusion between the write strobe and the illegal flag, always against the inputs one cycle earlier. What they cannot show is the reset values and the hold of result and carry across idle cycles. The bench's scenarios show these, along with back-to-back operations that switch variant on each cycle and a choice of unrecognised codes close to the legal ones.

// File: rtl/shr1_pkg.sv
package shr1_pkg;

   // Variant chosen by the decoder; SHK_NONE marks an unrecognised code.
   typedef enum logic [1:0] {
      SHK_ARITH = 2'd0,
      SHK_CARRY = 2'd1,
      SHK_LOGIC = 2'd2,
      SHK_NONE  = 2'd3
   } shr1_kind_e;

   localparam int unsigned SHR1_NUM_KINDS = 3;

endpackage

// File: rtl/shr1_decode.sv
module shr1_decode
   import shr1_pkg::*;
#(
   parameter int unsigned FUNC_W     = 16,
   parameter logic [FUNC_W-1:0] CODE_ARITH = 16'h0001,
   parameter logic [FUNC_W-1:0] CODE_CARRY = 16'h0021,
   parameter logic [FUNC_W-1:0] CODE_LOGIC = 16'h0041
) (
   input  logic [FUNC_W-1:0] func,
   output shr1_kind_e        kind,
   output logic              legal
);

   localparam logic [FUNC_W-1:0] CODES [SHR1_NUM_KINDS] = '{CODE_ARITH, CODE_CARRY, CODE_LOGIC};

   if ((CODE_ARITH == CODE_CARRY) || (CODE_ARITH == CODE_LOGIC) || (CODE_CARRY == CODE_LOGIC)) begin : g_bad_codes
      $error("shr1_decode: function codes must be distinct");
   end

   logic [SHR1_NUM_KINDS-1:0] hit;

   for (genvar k = 0; k < SHR1_NUM_KINDS; k++) begin : g_match
      assign hit[k] = (func == CODES[k]);
   end

   always_comb begin
      kind = SHK_NONE;
      unique case (1'b1)
         hit[0]:  kind = SHK_ARITH;
         hit[1]:  kind = SHK_CARRY;
         hit[2]:  kind = SHK_LOGIC;
         default: kind = SHK_NONE;
      endcase
   end

   assign legal = |hit;

endmodule

// File: rtl/shr1_core.sv
module shr1_core
   import shr1_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  shr1_kind_e        kind,
   input  logic [DATA_W-1:0] opnd,
   input  logic              carry_in,
   output logic [DATA_W-1:0] result,
   output logic              carry_out
);

   if (DATA_W < 2) begin : g_bad_width
      $error("shr1_core: DATA_W must be at least 2");
   end

   logic fill;

   always_comb begin
      unique case (kind)
         SHK_ARITH: fill = opnd[DATA_W-1];
         SHK_CARRY: fill = carry_in;
         SHK_LOGIC: fill = 1'b0;
         default:   fill = 1'b0;
      endcase
   end

   // Unrecognised codes pass the operand and the old carry through.
   always_comb begin
      if (kind == SHK_NONE) begin
         result    = opnd;
         carry_out = carry_in;
      end else begin
         result    = {fill, opnd[DATA_W-1:1]};
         carry_out = opnd[0];
      end
   end

endmodule

// File: rtl/shr1_outreg.sv
module shr1_outreg #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              legal,
   input  logic [DATA_W-1:0] result_d,
   input  logic              carry_d,
   output logic              valid_q,
   output logic [DATA_W-1:0] result_q,
   output logic              carry_q,
   output logic              we_q,
   output logic              illegal_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q   <= 1'b0;
         we_q      <= 1'b0;
         illegal_q <= 1'b0;
         result_q  <= '0;
         carry_q   <= 1'b0;
      end else begin
         valid_q   <= in_valid;
         we_q      <= in_valid & legal;
         illegal_q <= in_valid & ~legal;
         if (in_valid) begin
            result_q <= result_d;
            carry_q  <= carry_d;
         end
      end
   end

endmodule

// File: rtl/shr1_unit.sv
module shr1_unit
   import shr1_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned FUNC_W = 16,
   parameter logic [FUNC_W-1:0] CODE_ARITH = 16'h0001,
   parameter logic [FUNC_W-1:0] CODE_CARRY = 16'h0021,
   parameter logic [FUNC_W-1:0] CODE_LOGIC = 16'h0041
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [FUNC_W-1:0] in_func,
   input  logic [DATA_W-1:0] in_opnd,
   input  logic              in_carry,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic              out_carry,
   output logic              out_carry_we,
   output logic              out_illegal
);

   shr1_kind_e        kind;
   logic              legal;
   logic [DATA_W-1:0] result_d;
   logic              carry_d;

   shr1_decode #(
      .FUNC_W     (FUNC_W),
      .CODE_ARITH (CODE_ARITH),
      .CODE_CARRY (CODE_CARRY),
      .CODE_LOGIC (CODE_LOGIC)
   ) u_decode (
      .func  (in_func),
      .kind  (kind),
      .legal (legal)
   );

   shr1_core #(
      .DATA_W (DATA_W)
   ) u_core (
      .kind      (kind),
      .opnd      (in_opnd),
      .carry_in  (in_carry),
      .result    (result_d),
      .carry_out (carry_d)
   );

   shr1_outreg #(
      .DATA_W (DATA_W)
   ) u_outreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .legal     (legal),
      .result_d  (result_d),
      .carry_d   (carry_d),
      .valid_q   (out_valid),
      .result_q  (out_result),
      .carry_q   (out_carry),
      .we_q      (out_carry_we),
      .illegal_q (out_illegal)
   );

endmodule

// File: rtl/shr1_unit_chk.sv
module shr1_unit_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned FUNC_W = 16,
   parameter logic [FUNC_W-1:0] CODE_ARITH = 16'h0001,
   parameter logic [FUNC_W-1:0] CODE_CARRY = 16'h0021,
   parameter logic [FUNC_W-1:0] CODE_LOGIC = 16'h0041
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [FUNC_W-1:0] in_func,
   input logic [DATA_W-1:0] in_opnd,
   input logic              in_carry,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_result,
   input logic              out_carry,
   input logic              out_carry_we,
   input logic              out_illegal
);

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_low_bits_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_illegal || out_result[DATA_W-2:0] == $past(in_opnd[DATA_W-1:1])));

   assert_arith_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_func == CODE_ARITH) |=> out_result[DATA_W-1] == $past(in_opnd[DATA_W-1]));

   assert_carry_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_func == CODE_CARRY) |=> out_result[DATA_W-1] == $past(in_carry));

   assert_logic_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_func == CODE_LOGIC) |=> !out_result[DATA_W-1]);

   assert_carry_from_lsb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_illegal || out_carry == $past(in_opnd[0])));

   assert_we_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_carry_we |-> (out_valid && !out_illegal));

   assert_illegal_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> out_valid);

   assert_illegal_keeps_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (!out_illegal || (out_carry == $past(in_carry) && out_result == $past(in_opnd))));

   assert_valid_decided_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones({out_carry_we, out_illegal}) == 1);

endmodule

bind shr1_unit shr1_unit_chk #(
   .DATA_W     (DATA_W),
   .FUNC_W     (FUNC_W),
   .CODE_ARITH (CODE_ARITH),
   .CODE_CARRY (CODE_CARRY),
   .CODE_LOGIC (CODE_LOGIC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_func      (in_func),
   .in_opnd      (in_opnd),
   .in_carry     (in_carry),
   .out_valid    (out_valid),
   .out_result   (out_result),
   .out_carry    (out_carry),
   .out_carry_we (out_carry_we),
   .out_illegal  (out_illegal)
);

// File: tb/sim_shr1_unit.sv
`timescale 1ns/1ps
module sim_shr1_unit;

   localparam int CLK_PERIOD = 10;
   localparam int W = 32;
   localparam logic [15:0] F_ARITH = 16'h0001;
   localparam logic [15:0] F_CARRY = 16'h0021;
   localparam logic [15:0] F_LOGIC = 16'h0041;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [15:0]   in_func = '0;
   logic [W-1:0]  in_opnd = '0;
   logic          in_carry = 1'b0;
   logic          out_valid;
   logic [W-1:0]  out_result;
   logic          out_carry;
   logic          out_carry_we;
   logic          out_illegal;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shr1_unit u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_func      (in_func),
      .in_opnd      (in_opnd),
      .in_carry     (in_carry),
      .out_valid    (out_valid),
      .out_result   (out_result),
      .out_carry    (out_carry),
      .out_carry_we (out_carry_we),
      .out_illegal  (out_illegal)
   );

   task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Present one operation at a falling edge; after the next falling edge the
   // registered outputs reflect it.
   task automatic issue(input logic [15:0] f, input logic [W-1:0] op, input logic ci);
      in_valid = 1'b1;
      in_func  = f;
      in_opnd  = op;
      in_carry = ci;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic logic [W-1:0] model_result(input logic [15:0] f, input logic [W-1:0] op, input logic ci);
      if (f == F_ARITH) return {op[W-1], op[W-1:1]};
      if (f == F_CARRY) return {ci, op[W-1:1]};
      if (f == F_LOGIC) return {1'b0, op[W-1:1]};
      return op;
   endfunction

   task automatic run_legal(input string req, input logic [15:0] f, input logic [W-1:0] op, input logic ci);
      issue(f, op, ci);
      check("R2", {req, " valid"}, W'(out_valid), W'(1));
      check(req, "result", out_result, model_result(f, op, ci));
      check("R7", {req, " carry"}, W'(out_carry), W'(op[0]));
      check("R8", {req, " carry_we"}, W'(out_carry_we), W'(1));
      check("R8", {req, " illegal"}, W'(out_illegal), W'(0));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", "valid in reset", W'(out_valid), W'(0));
      check("R1", "we in reset", W'(out_carry_we), W'(0));
      check("R1", "illegal in reset", W'(out_illegal), W'(0));
      check("R1", "result in reset", out_result, '0);
      check("R1", "carry in reset", W'(out_carry), W'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "valid after reset", W'(out_valid), W'(0));
      check("R1", "result after reset", out_result, '0);
   endtask

   task automatic t_arith();
      run_legal("R4", F_ARITH, 32'h8000_0003, 1'b0);
      run_legal("R4", F_ARITH, 32'h7FFF_FFFE, 1'b1);
      check("R3", "arith low bits", {1'b0, out_result[W-2:0]}, {1'b0, 32'h3FFF_FFFF & 32'h7FFF_FFFF});
   endtask

   task automatic t_carry();
      run_legal("R5", F_CARRY, 32'h0000_0001, 1'b1);
      run_legal("R5", F_CARRY, 32'hFFFF_FFFF, 1'b0);
      run_legal("R5", F_CARRY, 32'h1234_5678, 1'b1);
   endtask

   task automatic t_logic();
      run_legal("R6", F_LOGIC, 32'hFFFF_FFFF, 1'b1);
      run_legal("R6", F_LOGIC, 32'hA5A5_A5A4, 1'b0);
      check("R3", "logic low bits", out_result, 32'h52D2_D2D2);
   endtask

   task automatic t_illegal();
      logic [15:0] bad [4] = '{16'h0000, 16'h0061, 16'h8041, 16'h0020};
      for (int i = 0; i < 4; i++) begin
         issue(bad[i], 32'hDEAD_BEEF, i[0]);
         check("R9", "illegal flag", W'(out_illegal), W'(1));
         check("R9", "valid with illegal", W'(out_valid), W'(1));
         check("R9", "we low", W'(out_carry_we), W'(0));
         check("R9", "carry kept", W'(out_carry), W'(i[0]));
         check("R9", "operand passed", out_result, 32'hDEAD_BEEF);
      end
   endtask

   task automatic t_hold();
      run_legal("R5", F_CARRY, 32'h0F0F_0F0F, 1'b0);
      in_opnd  = 32'hFFFF_0000;
      in_carry = 1'b1;
      in_func  = F_LOGIC;
      repeat (2) begin
         @(negedge clk);
         check("R2", "idle valid", W'(out_valid), W'(0));
         check("R8", "idle we", W'(out_carry_we), W'(0));
         check("R10", "held result", out_result, 32'h0787_8787);
         check("R10", "held carry", W'(out_carry), W'(1));
      end
   endtask

   task automatic t_back_to_back();
      logic [15:0] fs [3] = '{F_ARITH, F_CARRY, F_LOGIC};
      logic [W-1:0] ops [3] = '{32'hC000_0000, 32'h0000_0002, 32'h8000_0001};
      for (int i = 0; i < 3; i++) begin
         in_valid = 1'b1;
         in_func  = fs[i];
         in_opnd  = ops[i];
         in_carry = 1'b1;
         @(negedge clk);
         check("R2", "b2b valid", W'(out_valid), W'(1));
         check("R3", "b2b result", out_result, model_result(fs[i], ops[i], 1'b1));
         check("R7", "b2b carry", W'(out_carry), W'(ops[i][0]));
      end
      in_valid = 1'b0;
      @(negedge clk);
      check("R2", "b2b drop", W'(out_valid), W'(0));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_arith();
      t_carry();
      t_logic();
      t_illegal();
      t_hold();
      t_back_to_back();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule